// File: doc/BRIEF.md
# Interrupt Controller Processor Interface

This block sits between an interrupt distributor and one processor. The distributor offers, every cycle, its best pending interrupt as an identifier and an 8-bit priority. The block decides whether that interrupt may interrupt the processor. It drives a registered interrupt line when three conditions hold. The interface must be switched on. The priority must beat a programmable priority mask. The priority must also beat the priority of the interrupt the processor is already servicing.

Software talks to the block through a simple 32-bit register port. Reading the acknowledge register is the acknowledgement. The read returns the identifier and makes that interrupt the active one. It also tells the distributor which interrupt was taken, and it raises the running priority. Writing the identifier back to the end-of-interrupt register completes the interrupt. This restores the running priority that was in force before. The block holds a small stack of nested active interrupts for this purpose. Software can also read back the running priority and the distributor's current best candidate.

Top module: `irqc_cpu_if`

## Requirements
- R1: After reset the control register reads 0, the priority mask reads 0, the running priority (offset 0x014) reads 0xFF and `irq_o` is low.
- R2: Bit 0 of the control register (offset 0x000) enables signalling. While it is 0, `irq_o` is low in the cycle after, whatever the candidate.
- R3: A candidate qualifies only when its priority is strictly less than the 8-bit mask at offset 0x004. With a mask of 255, priority 254 qualifies and priority 255 does not.
- R4: A read of offset 0x00C with a qualifying candidate returns the candidate identifier in bits [9:0], with bits [31:10] zero. In the same cycle it raises `take_valid` with `take_id` equal to that identifier.
- R5: A read of offset 0x00C with no qualifying candidate returns 1023. It raises no `take_valid` and changes no state.
- R6: After an acknowledge, the running priority equals the taken priority. A new candidate qualifies only when its priority is strictly less than the running priority, so a lower numeric value means more urgent.
- R7: A write to offset 0x010 whose bits [9:0] match the most recently acknowledged, still active identifier completes it. The running priority returns to its value before that acknowledge, and `done_valid`/`done_id` pulse in that cycle.
- R8: A write to offset 0x010 whose identifier does not match the most recent active interrupt, or that arrives when nothing is active, is ignored. The running priority is unchanged and `done_valid` stays low.
- R9: `irq_o` is registered. It rises in the cycle after a candidate qualifies. It is low in the cycle after an acknowledge read.
- R10: At most 4 interrupts can be active and nested. While 4 are active, no candidate qualifies: `irq_o` stays low and an acknowledge read returns 1023.
- R11: A read of offset 0x018 returns the candidate identifier when `cand_valid` is high and 1023 otherwise. The read has no side effect on the running priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt identifier |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| irq_o | output | 1 | Registered interrupt request to the processor |
| take_valid | output | 1 | Acknowledge accepted this cycle |
| take_id | output | 10 | Identifier taken by the acknowledge |
| done_valid | output | 1 | Matching end-of-interrupt accepted this cycle |
| done_id | output | 10 | Identifier completed |

## Verification
The assertions assume two things about the bus. A read and a write never arrive in the same cycle. The distributor never offers identifier 1023 as a real candidate. The bench drives exactly one register access per cycle, or none. It uses only identifiers below 1023. It changes the candidate inputs on the falling edge, so each rising edge sees stable values. Nesting never goes past what the stack holds unless the bench does so on purpose, to check that a full stack blocks new interrupts.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
    localparam int ID_W    = 10;
    localparam int PRIO_W  = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 12;

    localparam logic [ID_W-1:0]   SPURIOUS_ID = '1;
    localparam logic [PRIO_W-1:0] IDLE_PRIO   = '1;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_ACK   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_EOI   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_RUN   = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_HPEND = 12'h018;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } irq_entry_t;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_MASK,
        SEL_ACK,
        SEL_EOI,
        SEL_RUN,
        SEL_HPEND,
        SEL_NONE
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CTRL:  return SEL_CTRL;
            OFS_MASK:  return SEL_MASK;
            OFS_ACK:   return SEL_ACK;
            OFS_EOI:   return SEL_EOI;
            OFS_RUN:   return SEL_RUN;
            OFS_HPEND: return SEL_HPEND;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] zext_id(input logic [ID_W-1:0] v);
        return {{(DATA_W-ID_W){1'b0}}, v};
    endfunction

    function automatic logic [DATA_W-1:0] zext_prio(input logic [PRIO_W-1:0] v);
        return {{(DATA_W-PRIO_W){1'b0}}, v};
    endfunction
endpackage

// File: rtl/irqc_cfg_regs.sv
`timescale 1ns/1ps
module irqc_cfg_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_t          wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              en_q,
    output logic [PRIO_W-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_CTRL) en_q   <= wdata[0];
            if (wr_sel == SEL_MASK) mask_q <= wdata[PRIO_W-1:0];
        end
    end

    // R1: the registers sit at their reset values in the first cycle after reset
    a_r1_reset_values: assert property (@(posedge clk)
        rst |=> (!en_q && mask_q == '0));
endmodule

// File: rtl/irqc_prio_stack.sv
`timescale 1ns/1ps
module irqc_prio_stack
    import irqc_pkg::*;
#(
    parameter int DEPTH = 4
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  irq_entry_t        push_entry,
    input  logic              eoi_req,
    input  logic [ID_W-1:0]   eoi_id,
    output logic [PRIO_W-1:0] run_prio,
    output logic              full,
    output logic              eoi_hit
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    irq_entry_t        slots [DEPTH];
    logic [CNT_W-1:0]  count_q;
    logic [IDX_W-1:0]  top_idx;
    logic [IDX_W-1:0]  wr_idx;
    irq_entry_t        top_entry;

    assign top_idx   = IDX_W'(count_q - 1'b1);
    assign wr_idx    = IDX_W'(count_q);
    assign top_entry = slots[top_idx];
    assign full      = (count_q == DEPTH_C);
    assign run_prio  = (count_q == '0) ? IDLE_PRIO : top_entry.prio;
    assign eoi_hit   = eoi_req && (count_q != '0) && (top_entry.id == eoi_id);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (push && !full) begin
            slots[wr_idx] <= push_entry;
            count_q       <= count_q + 1'b1;
        end else if (eoi_hit) begin
            count_q <= count_q - 1'b1;
        end
    end

    // R10: the signalling logic never offers a push to a full stack
    a_r10_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R10: the nesting count never exceeds the depth
    a_r10_depth_bound: assert property (@(posedge clk) disable iff (rst)
        count_q <= DEPTH_C);
    // R6: each acknowledge raises urgency, so the running value drops
    a_r6_push_lowers_running: assert property (@(posedge clk) disable iff (rst)
        push |=> (run_prio < $past(run_prio)));
    // R8: a non-matching completion leaves the nesting unchanged
    a_r8_mismatch_ignored: assert property (@(posedge clk) disable iff (rst)
        (eoi_req && !eoi_hit && !push) |=> $stable(count_q));
endmodule

// File: rtl/irqc_signal.sv
`timescale 1ns/1ps
module irqc_signal
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [PRIO_W-1:0] mask,
    input  logic              cand_valid,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic              stack_full,
    input  logic              ack_take,
    output logic              qualify,
    output logic              irq_q
);
    logic beats_mask;
    logic beats_running;

    assign beats_mask    = cand_prio < mask;
    assign beats_running = cand_prio < run_prio;
    assign qualify = en && cand_valid && beats_mask && beats_running && !stack_full;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= qualify && !ack_take;
    end

    // R2: a disabled interface gives a low request in the next cycle
    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !en |=> !irq_q);
    // R3: a raised request came from a priority below the mask
    a_r3_mask_respected: assert property (@(posedge clk) disable iff (rst)
        (!ack_take && !beats_mask) |=> !irq_q);
    // R9: the request is low in the cycle after an acknowledge
    a_r9_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
        ack_take |=> !irq_q);
endmodule

// File: rtl/irqc_cpu_if.sv
`timescale 1ns/1ps
module irqc_cpu_if
    import irqc_pkg::*;
#(
    parameter int STACK_DEPTH = 4
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        cand_valid,
    input  logic [9:0]  cand_id,
    input  logic [7:0]  cand_prio,
    output logic        irq_o,
    output logic        take_valid,
    output logic [9:0]  take_id,
    output logic        done_valid,
    output logic [9:0]  done_id
);
    reg_sel_t          sel;
    logic              en_q;
    logic [PRIO_W-1:0] mask_q;
    logic [PRIO_W-1:0] run_prio;
    logic              stack_full;
    logic              qualify;
    logic              ack_take;
    logic              eoi_req;
    logic              eoi_hit;
    irq_entry_t        cand_entry;
    logic              unused_wdata;

    assign sel          = decode_addr(bus_addr);
    assign cand_entry   = '{id: cand_id, prio: cand_prio};
    assign ack_take     = bus_rd && (sel == SEL_ACK) && qualify;
    assign eoi_req      = bus_wr && (sel == SEL_EOI);
    assign unused_wdata = ^bus_wdata[DATA_W-1:ID_W];

    irqc_cfg_regs u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr),
        .wr_sel (sel),
        .wdata  (bus_wdata),
        .en_q   (en_q),
        .mask_q (mask_q)
    );

    irqc_prio_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk        (clk),
        .rst        (rst),
        .push       (ack_take),
        .push_entry (cand_entry),
        .eoi_req    (eoi_req),
        .eoi_id     (bus_wdata[ID_W-1:0]),
        .run_prio   (run_prio),
        .full       (stack_full),
        .eoi_hit    (eoi_hit)
    );

    irqc_signal u_sig (
        .clk        (clk),
        .rst        (rst),
        .en         (en_q),
        .mask       (mask_q),
        .cand_valid (cand_valid),
        .cand_prio  (cand_prio),
        .run_prio   (run_prio),
        .stack_full (stack_full),
        .ack_take   (ack_take),
        .qualify    (qualify),
        .irq_q      (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_CTRL:  bus_rdata = {{(DATA_W-1){1'b0}}, en_q};
                SEL_MASK:  bus_rdata = zext_prio(mask_q);
                SEL_ACK:   bus_rdata = zext_id(qualify ? cand_id : SPURIOUS_ID);
                SEL_RUN:   bus_rdata = zext_prio(run_prio);
                SEL_HPEND: bus_rdata = zext_id(cand_valid ? cand_id : SPURIOUS_ID);
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign take_valid = ack_take;
    assign take_id    = cand_id;
    assign done_valid = eoi_hit;
    assign done_id    = bus_wdata[ID_W-1:0];

    // R4: an accepted acknowledge returns exactly the reported identifier
    a_r4_ack_data_matches: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> (bus_rdata == zext_id(take_id)));
    // R5: a spurious acknowledge reports no take
    a_r5_spurious_no_take: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_ACK && bus_rdata == zext_id(SPURIOUS_ID)) |-> !take_valid);
    // R7: a completion restores a less urgent (numerically higher) running value
    a_r7_done_raises_running: assert property (@(posedge clk) disable iff (rst)
        (done_valid && !take_valid) |=> (run_prio > $past(run_prio)));
endmodule

// File: tb/irqc_cpu_if_tb.sv
`timescale 1ns/1ps
module irqc_cpu_if_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cand_valid = 1'b0;
    logic [9:0]  cand_id = '0;
    logic [7:0]  cand_prio = 8'hFF;
    logic        irq_o, take_valid, done_valid;
    logic [9:0]  take_id, done_id;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference state
    bit       m_en = 0;
    int       m_mask = 0;
    bit       m_irq = 0;
    int       m_prio[$];
    int       m_id[$];

    always #4 clk = ~clk;

    irqc_cpu_if u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
        .irq_o(irq_o), .take_valid(take_valid), .take_id(take_id),
        .done_valid(done_valid), .done_id(done_id)
    );

    task automatic chk(input string tag, input string what, input longint got, input longint exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic int m_run();
        return (m_prio.size() == 0) ? 255 : m_prio[$];
    endfunction

    function automatic bit m_qual();
        return m_en && cand_valid && (int'(cand_prio) < m_mask) &&
               (int'(cand_prio) < m_run()) && (m_prio.size() < 4);
    endfunction

    task automatic cyc(input bit wr, input bit rd, input logic [11:0] a,
                       input logic [31:0] wd, input string tag);
        bit q, ackr, hit;
        longint exp_rd;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        #1;
        q    = m_qual();
        ackr = rd && (a == 12'h00C);
        hit  = wr && (a == 12'h010) && (m_id.size() != 0) && (int'(wd[9:0]) == m_id[$]);
        if (rd) begin
            case (a)
                12'h000: exp_rd = m_en;
                12'h004: exp_rd = m_mask;
                12'h00C: exp_rd = q ? cand_id : 1023;
                12'h014: exp_rd = m_run();
                12'h018: exp_rd = cand_valid ? cand_id : 1023;
                default: exp_rd = 0;
            endcase
            chk(tag, "rdata", bus_rdata, exp_rd);
        end
        if (ackr) begin
            chk(tag, "take_valid", take_valid, q);
            if (q) chk(tag, "take_id", take_id, cand_id);
        end
        if (wr && a == 12'h010) begin
            chk(tag, "done_valid", done_valid, hit);
            if (hit) chk(tag, "done_id", done_id, wd[9:0]);
        end
        @(posedge clk);
        #1;
        m_irq = q && !ackr;
        if (wr && a == 12'h000) m_en = wd[0];
        if (wr && a == 12'h004) m_mask = int'(wd[7:0]);
        if (ackr && q) begin
            m_prio.push_back(int'(cand_prio));
            m_id.push_back(int'(cand_id));
        end
        if (hit) begin
            void'(m_prio.pop_back());
            void'(m_id.pop_back());
        end
        chk("R9", "irq_o", irq_o, m_irq);
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 12'h000, 0, tag);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        cyc(0, 1, a, 0, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        cyc(1, 0, a, d, tag);
    endtask

    task automatic offer(input bit v, input logic [9:0] id, input logic [7:0] p);
        @(negedge clk);
        cand_valid = v; cand_id = id; cand_prio = p;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        // R1 reset state
        rd(12'h000, "R1");
        rd(12'h004, "R1");
        rd(12'h014, "R1");
        idle("R1");

        // R2 disabled interface never signals
        wr(12'h004, 32'hFF, "R3");
        offer(1, 10'd40, 8'h80);
        idle("R2"); idle("R2");
        rd(12'h00C, "R5");
        wr(12'h000, 32'h1, "R2");
        idle("R9"); idle("R9");

        // R3 mask boundary
        offer(1, 10'd40, 8'hFF);
        idle("R3"); idle("R3");
        offer(1, 10'd40, 8'hFE);
        idle("R3"); idle("R3");
        wr(12'h004, 32'h80, "R3");
        offer(1, 10'd40, 8'h80);
        idle("R3"); idle("R3");
        offer(1, 10'd40, 8'h7F);
        idle("R3"); idle("R3");

        // R4/R6 acknowledge
        rd(12'h00C, "R4");
        rd(12'h014, "R6");
        idle("R6");
        offer(1, 10'd41, 8'h7F);
        idle("R6"); idle("R6");
        offer(1, 10'd41, 8'h40);
        idle("R6");
        rd(12'h00C, "R4");
        rd(12'h014, "R6");

        // R8 mismatch ignored, R7 matching completion
        wr(12'h010, 32'd40, "R8");
        rd(12'h014, "R8");
        wr(12'h010, 32'd41, "R7");
        rd(12'h014, "R7");
        wr(12'h010, 32'd40, "R7");
        rd(12'h014, "R7");
        wr(12'h010, 32'd40, "R8");
        rd(12'h014, "R8");

        // R10 nesting limit
        wr(12'h004, 32'hFF, "R10");
        for (int k = 0; k < 4; k++) begin
            offer(1, 10'(k + 1), 8'(8'h70 - 8'(k * 16)));
            idle("R10");
            rd(12'h00C, "R10");
        end
        offer(1, 10'd9, 8'h10);
        idle("R10"); idle("R10");
        rd(12'h00C, "R10");
        rd(12'h014, "R10");
        for (int k = 4; k >= 1; k--) begin
            wr(12'h010, 32'(k), "R7");
        end
        rd(12'h014, "R7");
        idle("R9");

        // R11 highest pending readback, no side effect
        offer(1, 10'd5, 8'h20);
        rd(12'h018, "R11");
        rd(12'h014, "R11");
        offer(0, 10'd5, 8'h20);
        rd(12'h018, "R11");

        // R2 disabling drops a live request
        offer(1, 10'd6, 8'h20);
        idle("R2"); idle("R2");
        wr(12'h000, 32'h0, "R2");
        idle("R2");
        rd(12'h00C, "R5");
        rd(12'h000, "R2");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule